// File: doc/BRIEF.md
# Dual-Tier Watchdog Power Supervisor

This block supervises the supply and the resets of a small processor subsystem. Power comes up on any of three events: a press of the active-low power key, a charger being plugged in, or a battery being inserted. Once power is up, two independent watchdogs run on a shared timebase tick. The fast tier expects software to strobe a kick input. When the strobes stop, it pulses the processor reset for a fixed number of clock cycles. The slow tier expects a keep-alive pulse from the controller. When no pulse arrives within its window, it removes power. Software powers the system down on purpose by withholding the keep-alive pulses.

Two flags from external battery comparators control the system reset. The low flag marks a battery below the trip level. The ok flag marks a battery above the recovery level. The system reset is asserted as soon as the low flag is seen and is released only once the ok flag has been seen, so release has hysteresis. Each power-up starts with the system reset held until the battery is reported good.

Top module: `pwr_supervisor`

## Requirements
- R1: A falling edge on `key_n` while power is off sets `pwr_en` at the next clock edge.
- R2: A rising edge on `chg_det` while power is off sets `pwr_en` at the next clock edge.
- R3: A rising edge on `bat_det` while power is off sets `pwr_en` at the next clock edge. This includes a battery that is already present when reset is released.
- R4: Power-up reacts only to edges. A key held low, or a charger or battery that stays present, does not bring power back after a power-off.
- R5: Power drops on the clock edge of the SLOW_TICKS-th tick counted after the last keep-alive rising edge. The count restarts from zero at power-up, so software gets a full window after power-up. Ticks are counted only on edges after the edge that turned power on.
- R6: A keep-alive rising edge that falls on the same edge as the expiring tick wins. Power stays on and the window restarts from zero.
- R7: The fast tier counts ticks only while the system reset is released and the processor reset hold has ended. A kick restarts the count. On the FAST_TICKS-th tick without a kick, `cpu_rst` is high for exactly HOLD_CYCLES clock cycles and then falls.
- R8: Kicks arriving less than FAST_TICKS ticks apart keep `cpu_rst` low.
- R9: `bat_low` high while power is on asserts `sys_rst` and `cpu_rst` at the next edge. `pwr_en` is not affected.
- R10: After a low-battery event, `sys_rst` stays high while both flags are low. It falls at the first edge that sees `bat_ok` high and `bat_low` low.
- R11: At power-up `sys_rst` is high. It is released at the earliest one edge later, and only once `bat_ok` is high.
- R12: While power is off, and also after reset, `pwr_en` is 0 and both `sys_rst` and `cpu_rst` are 1. `cpu_rst` is high whenever `sys_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase strobe, one cycle wide |
| kick | input | 1 | Fast-tier service strobe |
| keepalive | input | 1 | Slow-tier keep-alive pulse; its rising edge is used |
| key_n | input | 1 | Power key, active low |
| chg_det | input | 1 | Charger present |
| bat_det | input | 1 | Battery present |
| bat_low | input | 1 | Battery below the trip threshold |
| bat_ok | input | 1 | Battery above the recovery threshold |
| pwr_en | output | 1 | Supply enable |
| sys_rst | output | 1 | System reset, active high |
| cpu_rst | output | 1 | Processor and DSP reset, active high |

## Verification
The keep-alive edge and the expiring slow-tier tick can land on the same clock edge. The bench provokes this by counting one tick short of the window and then raising keep-alive in the half-cycle before the final tick. It judges the result in two steps. Power must still be on after that edge. A further full window without pulses must then drop power on exactly its last tick, which shows that the count restarted at the coincident edge.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Power-up sources, one edge detector each
    typedef enum int unsigned {
        SRC_KEY = 0,
        SRC_CHG = 1,
        SRC_BAT = 2
    } wake_src_e;

    localparam int unsigned NUM_WAKE = 3;

endpackage

// File: rtl/supv_edge.sv
module supv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/supv_tier.sv
module supv_tier #(
    parameter int unsigned LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic tick,
    output logic expire
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (!run || clear) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                expire = 1'b1;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
    parameter int unsigned FAST_TICKS  = 500,
    parameter int unsigned SLOW_TICKS  = 1500,
    parameter int unsigned HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic kick,
    input  logic keepalive,
    input  logic key_n,
    input  logic chg_det,
    input  logic bat_det,
    input  logic bat_low,
    input  logic bat_ok,
    output logic pwr_en,
    output logic sys_rst,
    output logic cpu_rst
);
    import supv_pkg::*;

    localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic          pwr;
        logic          lowbat;
        logic [HW-1:0] hold;
    } supv_state_t;

    supv_state_t st_d, st_q;

    logic [NUM_WAKE-1:0] wake_lvl;
    logic [NUM_WAKE-1:0] wake_rise;
    logic                ka_rise;
    logic                slow_exp;
    logic                fast_exp;
    logic                fast_run;

    assign wake_lvl[SRC_KEY] = ~key_n;
    assign wake_lvl[SRC_CHG] = chg_det;
    assign wake_lvl[SRC_BAT] = bat_det;

    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_wake
        supv_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (wake_lvl[g]),
            .rise (wake_rise[g])
        );
    end

    supv_edge u_ka_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (keepalive),
        .rise (ka_rise)
    );

    // Slow tier: counter is zero while off, so power-up gives a full window
    supv_tier #(.LIMIT(SLOW_TICKS)) u_slow (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.pwr),
        .clear (ka_rise),
        .tick  (tick),
        .expire(slow_exp)
    );

    assign fast_run = st_q.pwr & ~st_q.lowbat & (st_q.hold == '0);

    supv_tier #(.LIMIT(FAST_TICKS)) u_fast (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (fast_run),
        .clear (kick),
        .tick  (tick),
        .expire(fast_exp)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.pwr) begin
            st_d.lowbat = 1'b1;
            st_d.hold   = '0;
            if (|wake_rise) begin
                st_d.pwr = 1'b1;
            end
        end else begin
            if (slow_exp) begin
                st_d.pwr = 1'b0;
            end
            if (bat_low) begin
                st_d.lowbat = 1'b1;
            end else if (bat_ok) begin
                st_d.lowbat = 1'b0;
            end
            if (fast_exp) begin
                st_d.hold = HW'(HOLD_CYCLES);
            end else if (st_q.hold != '0) begin
                st_d.hold = st_q.hold - HW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pwr: 1'b0, lowbat: 1'b1, hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_en  = st_q.pwr;
    assign sys_rst = ~st_q.pwr | st_q.lowbat;
    assign cpu_rst = sys_rst | (st_q.hold != '0);

endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic keepalive,
    input logic key_n,
    input logic chg_det,
    input logic bat_low,
    input logic bat_ok,
    input logic pwr_en,
    input logic sys_rst,
    input logic cpu_rst
);

    a_r12_off_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (sys_rst && cpu_rst));

    a_r12_cpu_covers_sys: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> cpu_rst);

    a_r1_key_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(key_n) && !pwr_en) |=> pwr_en);

    a_r2_charger_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(chg_det) && !pwr_en) |=> pwr_en);

    a_r6_keepalive_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && $rose(keepalive)) |=> pwr_en);

    a_r9_low_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bat_low |=> (sys_rst && cpu_rst));

    a_r10_release_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> ($past(bat_ok) && !$past(bat_low)));

    a_r11_powerup_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> sys_rst);

endmodule

bind pwr_supervisor pwr_supervisor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .keepalive(keepalive),
    .key_n    (key_n),
    .chg_det  (chg_det),
    .bat_low  (bat_low),
    .bat_ok   (bat_ok),
    .pwr_en   (pwr_en),
    .sys_rst  (sys_rst),
    .cpu_rst  (cpu_rst)
);

// File: tb/pwr_supervisor_bench.sv
`timescale 1ns/1ps
module pwr_supervisor_bench;

    localparam int FAST = 6;
    localparam int SLOW = 15;
    localparam int HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick = 1'b0, keepalive = 1'b0, key_n = 1'b1;
    logic chg_det = 1'b0, bat_det = 1'b0, bat_low = 1'b0, bat_ok = 1'b1;
    logic pwr_en, sys_rst, cpu_rst;
    logic [1:0] tdiv = 2'd0;
    logic tick;
    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    always @(negedge clk) tdiv <= tdiv + 2'd1;
    assign tick = (tdiv == 2'd0);

    pwr_supervisor #(.FAST_TICKS(FAST), .SLOW_TICKS(SLOW), .HOLD_CYCLES(HOLD)) u_pwr_supervisor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .keepalive(keepalive),
        .key_n(key_n), .chg_det(chg_det), .bat_det(bat_det), .bat_low(bat_low),
        .bat_ok(bat_ok), .pwr_en(pwr_en), .sys_rst(sys_rst), .cpu_rst(cpu_rst)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_ticks(int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!tick);
        end
        #1;
    endtask

    task automatic pulse_ka();
        @(negedge clk) keepalive = 1'b1;
        @(negedge clk) keepalive = 1'b0;
    endtask

    task automatic pulse_kick();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
    endtask

    task automatic t_reset();
        step();
        chk("R12", "pwr_en after reset", pwr_en, 1'b0);
        chk("R12", "sys_rst after reset", sys_rst, 1'b1);
        chk("R12", "cpu_rst after reset", cpu_rst, 1'b1);
    endtask

    task automatic t_battery_insert();
        @(negedge clk) bat_det = 1'b1;
        step();
        chk("R3", "pwr_en on insertion", pwr_en, 1'b1);
        chk("R11", "sys_rst at power-up", sys_rst, 1'b1);
        step();
        chk("R11", "sys_rst released with bat_ok", sys_rst, 1'b0);
    endtask

    task automatic t_slow_window();
        pulse_ka();
        wait_ticks(SLOW - 1);
        chk("R5", "pwr_en one tick before window end", pwr_en, 1'b1);
        wait_ticks(1);
        chk("R5", "pwr_en at window end", pwr_en, 1'b0);
        chk("R12", "sys_rst when off", sys_rst, 1'b1);
        chk("R12", "cpu_rst when off", cpu_rst, 1'b1);
        repeat (10) step();
        chk("R4", "battery level does not re-power", pwr_en, 1'b0);
    endtask

    task automatic t_key_held();
        @(negedge clk) key_n = 1'b0;
        step();
        chk("R1", "pwr_en on key press", pwr_en, 1'b1);
        wait_ticks(SLOW - 1);
        chk("R5", "preloaded window still open", pwr_en, 1'b1);
        wait_ticks(1);
        chk("R5", "preloaded window expires", pwr_en, 1'b0);
        repeat (10) step();
        chk("R4", "held key does not re-power", pwr_en, 1'b0);
        @(negedge clk) key_n = 1'b1;
    endtask

    task automatic t_charger();
        @(negedge clk) chg_det = 1'b1;
        step();
        chk("R2", "pwr_en on charger", pwr_en, 1'b1);
        wait_ticks(SLOW);
        chk("R5", "off after window with charger", pwr_en, 1'b0);
        repeat (10) step();
        chk("R4", "present charger does not re-power", pwr_en, 1'b0);
        @(negedge clk) chg_det = 1'b0;
    endtask

    task automatic t_fast_fire();
        @(negedge clk) key_n = 1'b0;
        @(negedge clk) key_n = 1'b1;
        step();
        chk("R1", "pwr_en for fast test", pwr_en, 1'b1);
        chk("R11", "sys_rst released", sys_rst, 1'b0);
        pulse_ka();
        pulse_kick();
        wait_ticks(FAST - 1);
        chk("R7", "cpu_rst low before fast limit", cpu_rst, 1'b0);
        wait_ticks(1);
        chk("R7", "cpu_rst at fast limit", cpu_rst, 1'b1);
        chk("R7", "sys_rst untouched by fast tier", sys_rst, 1'b0);
        chk("R7", "pwr_en untouched by fast tier", pwr_en, 1'b1);
        for (int i = 1; i < HOLD; i++) begin
            step();
            chk("R7", "cpu_rst during hold", cpu_rst, 1'b1);
        end
        step();
        chk("R7", "cpu_rst after hold", cpu_rst, 1'b0);
    endtask

    task automatic t_fast_serviced();
        for (int i = 0; i < 5; i++) begin
            pulse_ka();
            pulse_kick();
            wait_ticks(FAST - 2);
            chk("R8", "cpu_rst with regular kicks", cpu_rst, 1'b0);
            chk("R8", "pwr_en with regular pulses", pwr_en, 1'b1);
        end
    endtask

    task automatic t_low_battery();
        pulse_ka();
        pulse_kick();
        @(negedge clk) begin bat_low = 1'b1; bat_ok = 1'b0; end
        step();
        chk("R9", "sys_rst on low battery", sys_rst, 1'b1);
        chk("R9", "cpu_rst on low battery", cpu_rst, 1'b1);
        chk("R9", "pwr_en stays on", pwr_en, 1'b1);
        @(negedge clk) bat_low = 1'b0;
        repeat (3) step();
        chk("R10", "sys_rst held between thresholds", sys_rst, 1'b0 ^ 1'b1);
        @(negedge clk) bat_ok = 1'b1;
        step();
        chk("R10", "sys_rst released at recovery", sys_rst, 1'b0);
        pulse_kick();
    endtask

    task automatic t_coincident();
        pulse_ka();
        wait_ticks(SLOW - 1);
        chk("R6", "on before final tick", pwr_en, 1'b1);
        do begin @(negedge clk); #1; end while (!tick);
        keepalive = 1'b1;
        step();
        chk("R6", "keep-alive wins over expiry", pwr_en, 1'b1);
        @(negedge clk) keepalive = 1'b0;
        wait_ticks(SLOW - 1);
        chk("R6", "window restarted, still on", pwr_en, 1'b1);
        wait_ticks(1);
        chk("R6", "restarted window expires", pwr_en, 1'b0);
    endtask

    task automatic t_powerup_low();
        @(negedge clk) bat_ok = 1'b0;
        @(negedge clk) key_n = 1'b0;
        step();
        chk("R1", "pwr_en with weak battery", pwr_en, 1'b1);
        repeat (3) step();
        chk("R11", "sys_rst held without bat_ok", sys_rst, 1'b1);
        @(negedge clk) begin key_n = 1'b1; bat_ok = 1'b1; end
        step();
        chk("R11", "sys_rst released once bat_ok", sys_rst, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_battery_insert();
        t_slow_window();
        t_key_held();
        t_charger();
        t_fast_fire();
        t_fast_serviced();
        t_low_battery();
        t_coincident();
        t_powerup_low();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule